// File: doc/BRIEF.md
# Three-Region Configurable Activation Unit

This block approximates a scalar nonlinear activation function on one signed 16-bit fixed-point sample per request. The sample has 6 integer bits and 10 fractional bits. Two runtime thresholds split the number line into a lower, a middle and an upper region. Each region carries its own four coefficients, a polynomial degree and an output mode. One block can therefore stand in for a sigmoid, tanh, GeLU-like or exponential curve just by loading a different configuration.

A request is launched with a one-cycle `start`. The unit captures the sample together with the chosen region's settings, and `done` marks the cycle in which `y_out` holds the answer. In polynomial mode the answer comes from a shared Horner evaluator that takes one multiply-accumulate per cycle. The constant, zero and pass-through modes skip the evaluator and finish at once. `busy` shows that an evaluation is still running.

Top module: `act3_unit`

## Requirements
- R1: Region selection works with signed comparisons in this priority order: region 0 if `x < thr_lo`, otherwise region 2 if `x > thr_hi`, otherwise region 1. Both thresholds therefore belong to region 1. The thresholds are sampled at the start of each request.
- R2: The output mode is the 2-bit field `mode_in[2r+1:2r]` of the selected region r. Code 00 gives the polynomial value. Code 01 gives that region's a0. Code 10 gives 0. Code 11 gives the input x.
- R3: In modes 01, 10 and 11, `done` is high in the first cycle after the clock edge that accepts `start`, and `busy` stays low throughout.
- R4: In mode 00 with degree d = `deg_in[2r+1:2r]`, the evaluation runs as follows. The accumulator is 24-bit two's complement and starts at a_d. It then takes d steps, k = d-1 down to 0, each computing acc = wrap24(floor(acc*x/1024) + a_k). Coefficient a_k of region r sits at `coef_in[64r+16k +: 16]`. `done` rises d+1 cycles after the accepting cycle.
- R5: The polynomial result is the accumulator saturated to the 16-bit range [-32768, 32767].
- R6: The unit captures the sample and the selected region's coefficients, degree and mode when it accepts `start`. Later changes to `x_in`, `coef_in`, `deg_in`, `mode_in` or the thresholds do not alter the running request.
- R7: `start` is ignored while `busy` is high. Each accepted request produces exactly one single-cycle `done` pulse.
- R8: `busy` is high from the cycle after a polynomial request is accepted up to, but not including, the `done` cycle. `busy` and `done` are never high together.
- R9: `y_out` changes only in a `done` cycle. It then holds its value until the next result.
- R10: After reset, `busy` = 0, `done` = 0 and `y_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| x_in | input | 16 | Input sample, signed Q6.10 |
| thr_lo | input | 16 | Lower threshold, signed Q6.10 |
| thr_hi | input | 16 | Upper threshold, signed Q6.10 |
| coef_in | input | 192 | Coefficients, region r at [64r +: 64], a_k at [16k +: 16] within it |
| deg_in | input | 6 | Polynomial degree per region, 2 bits each |
| mode_in | input | 6 | Output mode per region, 2 bits each |
| busy | output | 1 | Polynomial evaluation in progress |
| done | output | 1 | One-cycle pulse: result valid |
| y_out | output | 16 | Result, signed Q6.10, held between requests |

## Verification
The hardest case to reach from the ports is a running polynomial request whose configuration is pulled out from under it. The bench does this by launching a cubic evaluation and then inverting every configuration input, the sample and the thresholds on the very next cycle. It also holds `start` high through the whole evaluation, which shows that neither the captured state nor the single `done` pulse can be disturbed. Other cases target the exact threshold values and the values one step past them, swapped thresholds, saturation in both directions, and a 24-bit accumulator wraparound. The bench's reference model checks all of these cycle by cycle.

// File: rtl/act3_pkg.sv
package act3_pkg;

    typedef enum logic [1:0] {
        MODE_POLY  = 2'b00,
        MODE_CONST = 2'b01,
        MODE_ZERO  = 2'b10,
        MODE_PASS  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        REG_LOW  = 2'd0,
        REG_MID  = 2'd1,
        REG_HIGH = 2'd2
    } region_e;

endpackage

// File: rtl/act3_region_dec.sv
module act3_region_dec
    import act3_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] lo_i,
    input  logic signed [W-1:0] hi_i,
    output region_e             region_o
);

    always_comb begin
        if (x_i < lo_i) begin
            region_o = REG_LOW;
        end else if (x_i > hi_i) begin
            region_o = REG_HIGH;
        end else begin
            region_o = REG_MID;
        end
    end

endmodule

// File: rtl/act3_horner_step.sv
module act3_horner_step #(
    parameter int W     = 16,
    parameter int FRAC  = 10,
    parameter int ACC_W = 24
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic signed [W-1:0]     x_i,
    input  logic signed [W-1:0]     coef_i,
    output logic signed [ACC_W-1:0] acc_o
);

    localparam int PROD_W = ACC_W + W;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [ACC_W-1:0]  coef_ext;

    always_comb begin
        prod     = acc_i * x_i;
        scaled   = prod >>> FRAC;
        coef_ext = {{(ACC_W-W){coef_i[W-1]}}, coef_i};
        acc_o    = scaled[ACC_W-1:0] + coef_ext;
    end

endmodule

// File: rtl/act3_bypass_mux.sv
module act3_bypass_mux
    import act3_pkg::*;
#(
    parameter int W = 16
) (
    input  mode_e               mode_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] a0_i,
    output logic signed [W-1:0] y_o
);

    always_comb begin
        unique case (mode_i)
            MODE_CONST: y_o = a0_i;
            MODE_PASS:  y_o = x_i;
            default:    y_o = '0;
        endcase
    end

endmodule

// File: rtl/act3_unit.sv
module act3_unit
    import act3_pkg::*;
#(
    parameter int W     = 16,
    parameter int FRAC  = 10,
    parameter int ACC_W = 24,
    parameter int NREG  = 3,
    parameter int NCOEF = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic signed [W-1:0]         x_in,
    input  logic signed [W-1:0]         thr_lo,
    input  logic signed [W-1:0]         thr_hi,
    input  logic [NREG*NCOEF*W-1:0]     coef_in,
    input  logic [NREG*$clog2(NCOEF)-1:0] deg_in,
    input  logic [NREG*2-1:0]           mode_in,
    output logic                        busy,
    output logic                        done,
    output logic signed [W-1:0]         y_out
);

    localparam int DEG_W  = $clog2(NCOEF);
    localparam int BANK_W = NCOEF * W;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((64'sd1 <<< (W-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ACC_W'(-(64'sd1 <<< (W-1)));

    typedef struct packed {
        logic                       busy;
        logic                       done;
        logic [DEG_W-1:0]           left;
        logic signed [ACC_W-1:0]    acc;
        logic signed [W-1:0]        x;
        logic [NCOEF-1:0][W-1:0]    coef;
        logic signed [W-1:0]        y;
    } state_t;

    state_t s_d, s_q;

    // per-region configuration views
    logic [NCOEF-1:0][W-1:0] bank_coef [NREG];
    logic [DEG_W-1:0]        bank_deg  [NREG];
    mode_e                   bank_mode [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_bank
        assign bank_coef[r] = coef_in[r*BANK_W +: BANK_W];
        assign bank_deg[r]  = deg_in[r*DEG_W +: DEG_W];
        assign bank_mode[r] = mode_e'(mode_in[r*2 +: 2]);
    end

    region_e region;

    act3_region_dec #(.W(W)) u_dec (
        .x_i      (x_in),
        .lo_i     (thr_lo),
        .hi_i     (thr_hi),
        .region_o (region)
    );

    logic [NCOEF-1:0][W-1:0] sel_coef;
    logic [DEG_W-1:0]        sel_deg;
    mode_e                   sel_mode;

    always_comb begin
        unique case (region)
            REG_LOW: begin
                sel_coef = bank_coef[0];
                sel_deg  = bank_deg[0];
                sel_mode = bank_mode[0];
            end
            REG_HIGH: begin
                sel_coef = bank_coef[2];
                sel_deg  = bank_deg[2];
                sel_mode = bank_mode[2];
            end
            default: begin
                sel_coef = bank_coef[1];
                sel_deg  = bank_deg[1];
                sel_mode = bank_mode[1];
            end
        endcase
    end

    logic signed [W-1:0] bypass_y;

    act3_bypass_mux #(.W(W)) u_mux (
        .mode_i (sel_mode),
        .x_i    (x_in),
        .a0_i   (sel_coef[0]),
        .y_o    (bypass_y)
    );

    logic [DEG_W-1:0]        step_idx;
    logic signed [ACC_W-1:0] step_acc;

    assign step_idx = s_q.left - DEG_W'(1);

    act3_horner_step #(.W(W), .FRAC(FRAC), .ACC_W(ACC_W)) u_step (
        .acc_i  (s_q.acc),
        .x_i    (s_q.x),
        .coef_i (s_q.coef[step_idx]),
        .acc_o  (step_acc)
    );

    function automatic logic signed [W-1:0] clamp(input logic signed [ACC_W-1:0] a);
        if (a > SAT_HI) begin
            return SAT_HI[W-1:0];
        end else if (a < SAT_LO) begin
            return SAT_LO[W-1:0];
        end
        return a[W-1:0];
    endfunction

    logic signed [W-1:0] top_coef;
    assign top_coef = sel_coef[sel_deg];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.x    = x_in;
                s_d.coef = sel_coef;
                s_d.left = sel_deg;
                if (sel_mode == MODE_POLY) begin
                    s_d.busy = 1'b1;
                    s_d.acc  = {{(ACC_W-W){top_coef[W-1]}}, top_coef};
                end else begin
                    s_d.y    = bypass_y;
                    s_d.done = 1'b1;
                end
            end
        end else if (s_q.left == '0) begin
            s_d.y    = clamp(s_q.acc);
            s_d.done = 1'b1;
            s_d.busy = 1'b0;
        end else begin
            s_d.acc  = step_acc;
            s_d.left = step_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = s_q.busy;
    assign done  = s_q.done;
    assign y_out = s_q.y;

endmodule

// File: rtl/act3_unit_chk.sv
module act3_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] y_out
);

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_quick_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(busy)) |-> $past(start));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(y_out));

endmodule

bind act3_unit act3_unit_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .y_out (y_out)
);

// File: tb/tb_act3_unit.sv
module tb_act3_unit;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst_n;
    logic               start;
    logic signed [15:0] x_in, thr_lo, thr_hi;
    logic [191:0]       coef_in;
    logic [5:0]         deg_in, mode_in;
    logic               busy, done;
    logic signed [15:0] y_out;

    act3_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .coef_in(coef_in),
        .deg_in(deg_in), .mode_in(mode_in),
        .busy(busy), .done(done), .y_out(y_out)
    );

    int     n_chk = 0;
    int     n_err = 0;
    bit     finished = 0;
    longint exp_y = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int ref_region(longint x, longint lo, longint hi);
        if (x < lo) return 0;
        if (x > hi) return 2;
        return 1;
    endfunction

    function automatic longint cf(int r, int k);
        return longint'($signed(coef_in[r*64 + k*16 +: 16]));
    endfunction

    function automatic longint w24(longint v);
        longint m = v & 64'hFFFFFF;
        if (m >= 64'h800000) m = m - 64'h1000000;
        return m;
    endfunction

    function automatic longint ref_poly(int r, longint x);
        int d = int'(deg_in[2*r +: 2]);
        longint acc = cf(r, d);
        for (int k = d - 1; k >= 0; k--) begin
            acc = w24(((acc * x) >>> 10) + cf(r, k));
        end
        if (acc > 32767) return 32767;
        if (acc < -32768) return -32768;
        return acc;
    endfunction

    task automatic set_region(input int r, input int a3, input int a2, input int a1,
                              input int a0, input int deg, input int mode);
        coef_in[r*64 +: 64] = {a3[15:0], a2[15:0], a1[15:0], a0[15:0]};
        deg_in[2*r +: 2]    = deg[1:0];
        mode_in[2*r +: 2]   = mode[1:0];
    endtask

    // one request, checked against the model on every cycle afterwards
    task automatic do_req(input int xv, input bit disturb, input string tag);
        int r, m, d, lat;
        longint val;
        logic signed [15:0] s_lo, s_hi;
        logic [191:0] s_cf;
        logic [5:0] s_dg, s_md;
        r = ref_region(xv, thr_lo, thr_hi);
        m = int'(mode_in[2*r +: 2]);
        d = int'(deg_in[2*r +: 2]);
        case (m)
            0: val = ref_poly(r, xv);
            1: val = cf(r, 0);
            2: val = 0;
            default: val = xv;
        endcase
        lat = (m == 0) ? d + 1 : 0;
        s_lo = thr_lo; s_hi = thr_hi; s_cf = coef_in; s_dg = deg_in; s_md = mode_in;
        @(negedge clk);
        x_in  = xv[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            x_in    = ~x_in;
            coef_in = ~coef_in;
            deg_in  = ~deg_in;
            mode_in = ~mode_in;
            thr_lo  = 16'sh7000;
            thr_hi  = -16'sh7000;
            start   = (lat > 1);
        end
        for (int c = 0; c <= lat + 2; c++) begin
            if (c == lat) exp_y = val;
            if (disturb && c == lat - 1) start = 1'b0;
            chk(busy == (c < lat), {tag, " busy"}, busy, c < lat);
            chk(done == (c == lat), {tag, " done"}, done, c == lat);
            chk(y_out == exp_y, {tag, " y_out"}, y_out, exp_y);
            @(negedge clk);
        end
        thr_lo = s_lo; thr_hi = s_hi; coef_in = s_cf; deg_in = s_dg; mode_in = s_md;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; x_in = '0;
        thr_lo = -16'sd1024; thr_hi = 16'sd2048;
        coef_in = '0; deg_in = '0; mode_in = '0;
        set_region(0, 0, 0, 0, -512, 0, 1);
        set_region(1, 100, -300, 1024, 50, 3, 0);
        set_region(2, 0, 0, 0, 0, 0, 3);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10 busy", busy, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(y_out == 16'sd0, "R10 y_out", y_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 boundaries, R2 modes, R4 cubic
        do_req(-1024, 0, "R1 at lower threshold R4");
        do_req(-1025, 0, "R1 below lower R2 const R3");
        do_req(2048, 0, "R1 at upper threshold R4");
        do_req(2049, 0, "R1 above upper R2 pass R3");
        do_req(0, 0, "R4 cubic at zero");
        do_req(700, 0, "R4 cubic");
        set_region(2, 0, 0, 0, 0, 0, 2);
        do_req(5000, 0, "R2 zero mode R3");

        // R4 degrees 0..2
        set_region(1, 100, -300, 1024, 50, 0, 0);
        do_req(700, 0, "R4 degree0");
        set_region(1, 100, -300, 1024, 50, 1, 0);
        do_req(700, 0, "R4 degree1");
        set_region(1, 100, -300, 1024, 50, 2, 0);
        do_req(-700, 0, "R4 degree2");

        // R5 saturation both ways
        set_region(1, 0, 0, 32767, 0, 1, 0);
        do_req(2048, 0, "R5 positive clamp");
        set_region(1, 0, 0, 32767, -32768, 1, 0);
        do_req(-1024, 0, "R5 negative clamp");

        // R4 accumulator wraparound
        thr_hi = 16'sh7FFF;
        set_region(1, 32767, 32767, 32767, 32767, 3, 0);
        do_req(32767, 0, "R4 wrap24");
        thr_hi = 16'sd2048;

        // R1 runtime thresholds and inverted order
        set_region(1, 100, -300, 1024, 50, 3, 0);
        thr_lo = 16'sd100;
        do_req(0, 0, "R1 moved threshold");
        thr_lo = 16'sd1000; thr_hi = -16'sd1000;
        do_req(0, 0, "R1 inverted low");
        do_req(2000, 0, "R1 inverted high");
        thr_lo = -16'sd1024; thr_hi = 16'sd2048;

        // R6 capture and R7 start ignored while busy
        do_req(1500, 1, "R6 R7 disturbed cubic");

        // R9 hold while idle inputs change
        x_in = 16'sd123; coef_in = ~coef_in;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(y_out == exp_y, "R9 idle hold", y_out, exp_y);
            chk(done == 1'b0, "R9 no done", done, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule